// File: doc/BRIEF.md
# Bus-Cycle Interrupt Timer

This block is a free-running up-counter that counts CPU bus cycles and raises an interrupt request when it wraps from all-ones to zero. Software loads the counter one byte at a time through two write-only registers on the CPU bus. The low byte sits at the base address and the high byte at the base address plus one. Because it counts up, software arms the timer for N cycles by loading 2^W - N, where W is the counter width.

The counter advances only while its value is nonzero. Zero is therefore a resting state. After the wrap the counter sits at zero and stays there until software loads it again. The interrupt output is a level. It stays high until software writes the low-byte register, which loads that byte and clears the request in the same access. Writing the high byte leaves a pending request untouched.

The counter width is two bytes of `BYTE_W` bits each. The bus address width and the base address are parameters.

Top module: `cyc_irq_timer`

## Requirements
- R1: Synchronous active-high reset drives `irq_o` low and the counter to zero. With no register write after reset, no number of ticks raises `irq_o`.
- R2: On each clock edge where `tick_i` is high, the counter is nonzero and no register write is accepted, the counter increases by one. Edges with `tick_i` low leave it unchanged.
- R3: `irq_o` goes high on the clock edge whose increment takes the counter from all-ones to zero. After loading value v, that happens on exactly the (2^(2*BYTE_W) - v)-th tick.
- R4: A counter at zero does not advance. After a wrap, the counter stays at zero, and no second request appears until software loads it again.
- R5: Once high, `irq_o` stays high until a write to the low-byte register. That write drives it low on the next edge.
- R6: A write to the high-byte register does not change `irq_o`.
- R7: A register write accepted on an edge takes priority over the increment on that edge. No count and no wrap happen on that edge, so `irq_o` does not rise on it.
- R8: With `we_i` high, a write to `BASE_ADDR` loads counter bits [BYTE_W-1:0] from `data_i`. A write to `BASE_ADDR`+1 loads bits [2*BYTE_W-1:BYTE_W]. Writes to any other address, and any cycle with `we_i` low, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Qualifies one CPU bus cycle to count |
| we_i | input | 1 | CPU write strobe |
| addr_i | input | ADDR_W | CPU address |
| data_i | input | BYTE_W | CPU write data |
| irq_o | output | 1 | Interrupt request level, active high |

## Verification
The bench builds the timer with `BYTE_W` = 4, which gives an 8-bit counter and a 4-bit data bus. At that size, every nonzero load value from 1 to 255 can be swept. For each value, the bench checks the tick on which the wrap should fire and the tick before it. This covers every carry chain and both byte lanes. The small width also makes it cheap to let the counter sit at zero for more ticks than a full wrap would take. It likewise keeps short the directed cases: pausing, a write landing on the wrap edge, and writes to addresses that must be ignored.

// File: rtl/cit_pkg.sv
package cit_pkg;
  // number of byte-wide load registers making up the counter
  localparam int unsigned CIT_LANES = 2;

  // index of the lane whose write also acknowledges the request
  localparam int unsigned CIT_ACK_LANE = 0;
endpackage

// File: rtl/cit_decode.sv
module cit_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4100,
  parameter int unsigned LANES = 2
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LANES-1:0]  sel_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + ADDR_W'(i));
    assign sel_o[i] = we_i && (addr_i == LANE_ADDR);
  end

  // R8: at most one lane is selected by a single access
  always_comb begin
    a_one_lane_r8: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [LANES-1:0]  sel_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              wrap_o
);
  localparam int unsigned CNT_W = BYTE_W * LANES;

  logic [BYTE_W-1:0] lane_q [LANES];
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  inc_w;
  logic              any_wr;
  logic              advance;

  for (genvar i = 0; i < LANES; i++) begin : g_join
    assign cnt_w[i*BYTE_W +: BYTE_W] = lane_q[i];
  end

  assign any_wr  = |sel_i;
  assign inc_w   = cnt_w + CNT_W'(1);
  assign advance = tick_i && !any_wr && (cnt_w != '0);
  assign wrap_o  = advance && (&cnt_w);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q[i] <= '0;
      end else if (sel_i[i]) begin
        lane_q[i] <= data_i;
      end else if (advance) begin
        lane_q[i] <= inc_w[i*BYTE_W +: BYTE_W];
      end
    end

    // R8: a selected lane takes the bus data
    p_lane_load_r8: assert property (@(posedge clk) disable iff (rst)
      sel_i[i] |=> lane_q[i] == $past(data_i));
  end

  // R2: one step per qualified cycle
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !any_wr && cnt_w != '0) |=> cnt_w == $past(cnt_w) + CNT_W'(1));

  // R2: no tick, no write, no change
  p_pause_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !any_wr) |=> $stable(cnt_w));

  // R4: zero is a resting state
  p_zero_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_w == '0 && !any_wr) |=> cnt_w == '0);

  // R7: a write on the wrap edge suppresses the wrap
  p_wr_prio_r7: assert property (@(posedge clk) disable iff (rst)
    any_wr |-> !wrap_o);
endmodule

// File: rtl/cit_irq_flag.sv
module cit_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (clr_i) begin
      irq_q <= 1'b0;
    end else if (set_i) begin
      irq_q <= 1'b1;
    end
  end

  assign irq_o = irq_q;

  // R5: acknowledge drops the request
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !irq_q);

  // R5: request holds until acknowledged
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_i) |=> irq_q);
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              irq_o
);
  import cit_pkg::*;

  localparam int unsigned LANES = CIT_LANES;

  logic [LANES-1:0] sel_w;
  logic             wrap_w;
  logic             ack_w;
  logic             hi_wr_w;

  cit_decode #(
    .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .LANES(LANES)
  ) u_decode (
    .we_i(we_i),
    .addr_i(addr_i),
    .sel_o(sel_w)
  );

  cit_counter #(
    .BYTE_W(BYTE_W),
    .LANES(LANES)
  ) u_counter (
    .clk(clk),
    .rst(rst),
    .tick_i(tick_i),
    .sel_i(sel_w),
    .data_i(data_i),
    .wrap_o(wrap_w)
  );

  assign ack_w   = sel_w[CIT_ACK_LANE];
  assign hi_wr_w = sel_w[LANES-1];

  cit_irq_flag u_flag (
    .clk(clk),
    .rst(rst),
    .set_i(wrap_w),
    .clr_i(ack_w),
    .irq_o(irq_o)
  );

  // R1: reset leaves the request low
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> !irq_o);

  // R3: a wrap raises the request on the next cycle
  p_wrap_irq_r3: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> irq_o);

  // R6: high-byte write keeps a pending request
  p_hi_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && hi_wr_w && !ack_w) |=> irq_o);
endmodule

// File: tb/tb_cyc_irq_timer.sv
module tb_cyc_irq_timer;
  localparam int unsigned BW = 4;
  localparam int unsigned AW = 16;
  localparam logic [AW-1:0] LO = 16'h4100;
  localparam logic [AW-1:0] HI = 16'h4101;
  localparam int unsigned FULL = 1 << (2 * BW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] data = '0;
  logic irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cyc_irq_timer #(.BYTE_W(BW), .ADDR_W(AW), .BASE_ADDR(LO)) dut (
    .clk(clk), .rst(rst), .tick_i(tick), .we_i(we),
    .addr_i(addr), .data_i(data), .irq_o(irq)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s: irq actual=%0b expected=%0b", req, irq, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; data = d;
    @(negedge clk);
    we = 1'b0; addr = '0; data = '0;
  endtask

  task automatic load(input int v);
    wr(LO, BW'(v));
    wr(HI, BW'(v >> BW));
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1'b0, "R1 reset");
    ticks(FULL + 20);
    check(1'b0, "R1 R4 idle zero");

    // R3 sweep of every nonzero load value
    for (int v = 1; v < FULL; v++) begin
      int n;
      n = FULL - v;
      load(v);
      check(1'b0, "R5 low write acks");
      ticks(n - 1);
      check(1'b0, "R3 before wrap");
      ticks(1);
      check(1'b1, "R3 at wrap");
    end

    // R5 hold and R6 high write
    ticks(50);
    check(1'b1, "R5 hold");
    wr(HI, 4'h3);
    check(1'b1, "R6 high write keeps");
    // high lane is now 3, low lane 0 from wrap; counter 0x30 is nonzero
    wr(LO, 4'h0);
    check(1'b0, "R5 low write clears");
    // counter 0x30 counts to wrap in 0xD0 ticks
    ticks(FULL - 8'h30 - 1);
    check(1'b0, "R8 high lane loaded");
    ticks(1);
    check(1'b1, "R8 high lane wrap");

    // R4 stop after wrap
    wr(LO, 4'h0);
    ticks(FULL + 30);
    check(1'b0, "R4 stopped at zero");

    // R2 pause
    load(8'hF0);
    ticks(5);
    repeat (20) @(negedge clk);
    ticks(10);
    check(1'b0, "R2 paused ticks");
    ticks(1);
    check(1'b1, "R2 resumed wrap");

    // R7 write on the wrap edge
    load(8'hFF);
    @(negedge clk);
    tick = 1'b1; we = 1'b1; addr = HI; data = 4'hE;
    @(negedge clk);
    tick = 1'b0; we = 1'b0; addr = '0; data = '0;
    check(1'b0, "R7 write beats wrap");
    ticks(16);
    check(1'b0, "R7 reloaded count");
    ticks(1);
    check(1'b1, "R7 later wrap");

    // R8 ignored writes
    load(8'hF0);
    wr(16'h4102, 4'h0);
    wr(16'h4000, 4'h0);
    wr(16'h4200, 4'h0);
    @(negedge clk);
    we = 1'b0; addr = LO; data = 4'h9;
    @(negedge clk);
    addr = HI;
    @(negedge clk);
    addr = '0; data = '0;
    ticks(15);
    check(1'b0, "R8 foreign writes ignored");
    ticks(1);
    check(1'b1, "R8 foreign writes ignored wrap");

    // R1 reset mid-request
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1'b0, "R1 reset clears");
    ticks(FULL + 5);
    check(1'b0, "R1 counter zeroed");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule